// File: doc/BRIEF.md
# Converter I2C Slave Port

This block is the two-wire serial port of a sampling converter. It watches the open-drain clock and data lines in the system clock domain and finds bus Start, Repeated Start and Stop conditions. It answers one 7-bit bus address, picked from nine by a select input. A write transaction loads a 6-bit configuration word for the converter. A read transaction returns the most recent 12-bit conversion result.

The block also holds a small conversion model. A Stop that closes a transaction in which the block was addressed starts a conversion. The model then holds busy for a fixed number of system clocks. At the end it captures the result word from its input. While the conversion runs, the block refuses its own address, so a master can poll for completion by retrying the address.

The block never drives the data line high. Its only data output is a pull-low enable for an external open-drain pad.

Top module: `adc_i2c_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `busy_o` is 0 and `cfg_o` is 0.
- R2: The block answers the 7-bit address `BASE_ADDR + sel`, where `sel` is `addr_sel_i` limited to the range 0..8 (any value above 8 counts as 8). The default `BASE_ADDR` is 0x08. The first byte after a Start is the address in bits 7:1 and R/W in bit 0, with 1 meaning read. A byte with any other address is not acknowledged, and the rest of that transaction is ignored.
- R3: Data is only ever pulled low, never driven high. The pull-low enable turns on only while the synchronized clock line is low, and it is off whenever the block is not acknowledging or sending a 0 bit.
- R4: A Start, or a Repeated Start, arriving in the middle of a byte drops the partial byte and begins a fresh address phase.
- R5: On a write, each data byte is acknowledged. Its bits 7:2 become `cfg_o` when the acknowledge is given.
- R6: An address byte that matches while `busy_o` is 1 is not acknowledged. Data stays released through the acknowledge bit.
- R7: A read sends two bytes, most significant bit first. The first byte is result bits 11:4. The second byte is result bits 3:0 followed by four zero bits.
- R8: After the master does not acknowledge a read byte, the block releases data and sends nothing more.
- R9: A Stop that ends a transaction in which the block was addressed asserts `conv_start_o` for one cycle. It then raises `busy_o` for exactly `CONV_CYCLES` cycles and captures `result_i` as the new result when busy drops. A Stop that ends a transaction in which the block was not addressed starts nothing.
- R10: A Repeated Start between a write and a read keeps the transaction open. No conversion starts until the final Stop, and the read is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 4 | Address select, 0..8 |
| result_i | input | 12 | Converter output word, captured at the end of a conversion |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| cfg_o | output | 6 | Configuration word from the last write |
| busy_o | output | 1 | Conversion in progress |
| conv_start_o | output | 1 | One-cycle conversion launch pulse |

## Verification
A wrong state in the byte engine shows at the bus within one bit time. An acknowledge lands in the wrong bit, read data slides by one position, or data stays held low after a master refusal. A wrong session flag shows only at the next Stop, as a conversion that should not start or one that is missing. That is seen on `busy_o` a few cycles after Stop. A miscounted conversion timer shows as a busy window of the wrong length, or as a stale word in the next read.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int CFG_W  = 6;
    localparam int RES_W  = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } link_state_e;

    typedef struct packed {
        link_state_e       st;
        logic [CNT_W-1:0]  bits;
        logic [BYTE_W-1:0] shift;
        logic [BYTE_W-1:0] tx;
        logic              rw;
        logic              oe;
        logic              sel;
        logic [1:0]        rd_idx;
        logic              mack;
        logic [CFG_W-1:0]  cfg;
    } link_t;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] scl_sh_q, scl_sh_d;
    logic [SH_W-1:0] sda_sh_q, sda_sh_d;
    logic scl_prev, sda_prev;

    always_comb begin
        scl_sh_d = {scl_sh_q[SH_W-2:0], scl_i};
        sda_sh_d = {sda_sh_q[SH_W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
        end
    end

    assign scl_lvl   = scl_sh_q[SYNC_STAGES-1];
    assign sda_lvl   = sda_sh_q[SYNC_STAGES-1];
    assign scl_prev  = scl_sh_q[SYNC_STAGES];
    assign sda_prev  = sda_sh_q[SYNC_STAGES];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CONV_CYCLES = 200,
    parameter int RES_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [RES_W-1:0] result_i,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o
);
    localparam int TW = $clog2(CONV_CYCLES + 1);

    logic [TW-1:0]    cnt_q, cnt_d;
    logic [RES_W-1:0] res_q, res_d;

    always_comb begin
        cnt_d = cnt_q;
        res_d = res_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
            if (cnt_q == TW'(1)) res_d = result_i;
        end else if (go_i) begin
            cnt_d = TW'(CONV_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            res_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            res_q <= res_d;
        end
    end

    assign busy_o   = (cnt_q != '0);
    assign result_o = res_q;

endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave
    import adc_i2c_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR   = 7'h08,
    parameter int         NUM_ADDR    = 9,
    parameter int         CONV_CYCLES = 200,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [3:0]       addr_sel_i,
    input  logic [RES_W-1:0] result_i,
    output logic             sda_oe_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             busy_o,
    output logic             conv_start_o
);
    localparam logic [3:0] SEL_MAX = 4'(NUM_ADDR - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [RES_W-1:0] res_w;
    logic [3:0]       sel_c;
    logic [6:0]       my_addr;
    logic             conv_go;
    link_t            q, d;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    conv_timer #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .go_i(conv_go), .result_i(result_i),
        .busy_o(busy_o), .result_o(res_w)
    );

    always_comb begin
        sel_c   = (addr_sel_i > SEL_MAX) ? SEL_MAX : addr_sel_i;
        my_addr = BASE_ADDR + 7'(sel_c);
    end

    always_comb begin
        d       = q;
        conv_go = 1'b0;
        if (start_det) begin
            d.st   = ST_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (stop_det) begin
            d.st    = ST_IDLE;
            d.bits  = '0;
            d.oe    = 1'b0;
            d.sel   = 1'b0;
            conv_go = q.sel;
        end else begin
            case (q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise && q.bits < LAST_BIT) begin
                        d.shift = {q.shift[BYTE_W-2:0], sda_lvl};
                        d.bits  = q.bits + CNT_W'(1);
                    end else if (scl_fall && q.bits == LAST_BIT) begin
                        if (q.st == ST_ADDR) begin
                            if (q.shift[7:1] == my_addr && !busy_o) begin
                                d.oe  = 1'b1;
                                d.rw  = q.shift[0];
                                d.sel = 1'b1;
                                d.st  = ST_ADDR_ACK;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else begin
                            d.cfg = q.shift[BYTE_W-1:BYTE_W-CFG_W];
                            d.oe  = 1'b1;
                            d.st  = ST_WR_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.rw) begin
                            d.tx     = res_w[RES_W-1:RES_W-BYTE_W];
                            d.oe     = ~res_w[RES_W-1];
                            d.rd_idx = 2'd0;
                            d.st     = ST_RD;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WR;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe   = 1'b0;
                        d.bits = '0;
                        d.st   = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.bits = q.bits + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (q.bits == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = ST_RD_ACK;
                        end else begin
                            d.tx = {q.tx[BYTE_W-2:0], 1'b1};
                            d.oe = ~q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.tx     = (q.rd_idx == 2'd0) ?
                                       {res_w[RES_W-BYTE_W-1:0], {(2*BYTE_W-RES_W){1'b0}}} :
                                       {BYTE_W{1'b1}};
                            d.oe     = (q.rd_idx == 2'd0) ? ~res_w[RES_W-BYTE_W-1] : 1'b0;
                            d.rd_idx = (q.rd_idx == 2'd3) ? q.rd_idx : q.rd_idx + 2'd1;
                            d.bits   = '0;
                            d.st     = ST_RD;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o     = q.oe;
    assign cfg_o        = q.cfg;
    assign conv_start_o = conv_go;

endmodule

// File: rtl/adc_i2c_slave_chk.sv
module adc_i2c_slave_chk
    import adc_i2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_lvl,
    input link_state_e      st,
    input logic             sda_oe_o,
    input logic             busy_o,
    input logic             conv_start_o,
    input logic [CFG_W-1:0] cfg_o
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sda_oe_o && !$past(sda_oe_o)) |-> !scl_lvl); // R3

    AST_NAK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && st == ST_ADDR_ACK && $past(st) != ST_ADDR_ACK) |-> !$past(busy_o)); // R6

    AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> busy_o); // R9

    AST_NO_GO_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !conv_start_o); // R9

    AST_CFG_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && cfg_o != $past(cfg_o)) |-> st == ST_WR_ACK); // R5

endmodule

bind adc_i2c_slave adc_i2c_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .st(q.st),
    .sda_oe_o(sda_oe_o), .busy_o(busy_o), .conv_start_o(conv_start_o),
    .cfg_o(cfg_o)
);

// File: tb/test_adc_i2c_slave.sv
`timescale 1ns/1ps
module test_adc_i2c_slave;
    localparam int CONV = 2000;
    localparam int H    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [3:0] addr_sel = 4'd3;
    logic [11:0] result = 12'h000;
    logic sda_oe, busy, conv_start;
    logic [5:0] cfg;
    logic sda_bus;

    int n_vec = 0, n_bad = 0;
    int busy_run = 0, last_len = 0;
    bit done = 0;

    typedef struct { string tag; int val; } item_t;
    item_t exp_q[$];
    int    obs_q[$];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    adc_i2c_slave #(.CONV_CYCLES(CONV)) i_adc_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel_i(addr_sel), .result_i(result), .sda_oe_o(sda_oe),
        .cfg_o(cfg), .busy_o(busy), .conv_start_o(conv_start)
    );

    // monitor: compares in arrival order
    always @(negedge clk) begin
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            item_t e;
            int o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            n_vec++;
            if (o != e.val) begin
                n_bad++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", e.tag, o, e.val);
            end
        end
    end

    always @(negedge clk) begin
        if (busy) busy_run++;
        else if (busy_run != 0) begin
            last_len = busy_run;
            busy_run = 0;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int actual, int expv);
        exp_q.push_back('{tag, expv});
        obs_q.push_back(actual);
    endtask

    task automatic m_start;
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic m_rstart;
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic m_stop;
        tick(H/2); sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic m_bit(input logic b, output logic r);
        tick(H/2); sda_m = b; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        r = sda_bus; tick(H/2);
        scl_m = 1'b0;
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic ack_n);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
        m_bit(1'b1, ack_n);
    endtask

    task automatic m_rbyte(input logic mack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(1'b1, v[i]);
        m_bit(~mack, r);
    endtask

    task automatic wait_idle;
        while (busy) tick(1);
        tick(5);
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 cfg", cfg, 0);

        result = 12'hABC;
        // write configuration to address 0x0B
        m_start;
        m_wbyte(8'h16, a); chk("R2 address ack", a, 0);
        m_wbyte(8'hA4, a); chk("R5 data ack", a, 0);
        tick(2); chk("R5 cfg", cfg, 6'h29);
        m_stop;
        tick(2); chk("R9 busy after stop", busy, 1);

        // poll while busy
        m_start;
        m_wbyte(8'h17, a); chk("R6 nak while busy", a, 1);
        m_stop;
        wait_idle;
        chk("R9 busy length", last_len, CONV);

        // read result
        m_start;
        m_wbyte(8'h17, a); chk("R2 read address ack", a, 0);
        m_rbyte(1'b1, b); chk("R7 high byte", b, 8'hAB);
        m_rbyte(1'b0, b); chk("R7 low byte", b, 8'hC0);
        m_bit(1'b1, a);   chk("R8 released after nak", a, 1);
        m_stop;
        result = 12'h5A3;
        tick(2); chk("R9 read starts conversion", busy, 1);
        wait_idle;
        chk("R9 busy length again", last_len, CONV);

        // foreign address
        m_start;
        m_wbyte(8'h40, a); chk("R2 foreign address nak", a, 1);
        m_wbyte(8'h00, a); chk("R2 rest ignored", a, 1);
        m_stop;
        tick(20); chk("R9 no conversion", busy, 0);

        // write, repeated start, read
        m_start;
        m_wbyte(8'h16, a); chk("R10 write address ack", a, 0);
        m_wbyte(8'h18, a); chk("R5 second write ack", a, 0);
        tick(2); chk("R5 cfg second", cfg, 6'h06);
        m_rstart;
        chk("R10 no conversion at Sr", busy, 0);
        m_wbyte(8'h17, a); chk("R10 read after Sr ack", a, 0);
        m_rbyte(1'b1, b); chk("R7 captured high", b, 8'h5A);
        m_rbyte(1'b0, b); chk("R7 captured low", b, 8'h30);
        m_stop;
        tick(2); chk("R10 conversion at stop", busy, 1);
        wait_idle;

        // partial byte abort, clamped select
        addr_sel = 4'd12;
        m_start;
        for (int i = 0; i < 4; i++) m_bit(1'b1, a);
        m_rstart;
        m_wbyte(8'h20, a); chk("R4 R2 abort and clamped address", a, 0);
        m_stop;
        tick(2); chk("R3 released after stop", sda_oe, 0);
        wait_idle;

        tick(4);
        n_bad += exp_q.size();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule